// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast input clock by an integer N for the feedback path of a phase-locked loop. A dual-modulus prescaler divides by 64 or by 65. A fixed main counter, built from a divide-by-12 stage followed by a divide-by-6 stage, counts 72 prescaler pulses per output period. A 6-bit swallow down-counter holds the prescaler at 65 for the first A prescaler cycles of each period and then lets it fall back to 64, so the ratio is N = 64·72 + A = 4608 + A.

The swallow value A is taken from the `a_i` input only at the boundary between two periods, when the main counter wraps, and at reset. The value is clamped into the range 27 to 42, so 16 ratios from 4635 to 4650 are available. The block emits one single-cycle pulse per N input clocks, and it also exposes which modulus the prescaler is currently using.

Top module: `psd_divider`

## Requirements
- R1: While `rst_i` is high and after its release `div_o` is low; the first `div_o` pulse is seen exactly N rising edges after the first edge that samples `rst_i` low, with N taken from the `a_i` value present during reset.
- R2: With `a_i` held at a value A from 27 to 42, consecutive `div_o` pulses are exactly 4608 + A input clocks apart, for each of the 16 values.
- R3: Every `div_o` pulse is high for exactly one input clock.
- R4: `modsel_o` is 1 while the prescaler divides by 65 and 0 while it divides by 64; across each full period it is high for exactly 65·A clocks, and it rises only on the clock where `div_o` is high.
- R5: A change of `a_i` during a period has no effect on that period; the new ratio applies from the next period on.
- R6: Values of `a_i` below 27 act as 27 and values above 42 act as 42 (so `a_i` = 0 gives 4635 and `a_i` = 63 gives 4650).
- R7: A reset asserted in the middle of a period discards it, and the next pulse follows R1 for the `a_i` value present during that reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| a_i | input | 6 | Swallow count A; it is sampled at reset and at each period boundary |
| div_o | output | 1 | One-clock pulse per N input clocks (registered) |
| modsel_o | output | 1 | 1 when the prescaler divides by 65, 0 when it divides by 64 |

## Verification
The case that is hardest to bring about is a change of `a_i` that lands inside a period. If that change leaked into the running swallow count, the period would come out at some ratio between the old and the new value. The stimulus therefore changes `a_i` either just after a pulse or a hundred clocks into a period. It then measures both the period that contains the change, which must keep the old N, and the following one, which must use the new N. The full sweep of A, the two clamp extremes and a reset in mid-period are all reached through the same period measurement.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int PRE_P   = 64;  // base prescaler modulus (P / P+1)
  localparam int MAIN_LO = 12;  // first main-counter stage
  localparam int MAIN_HI = 6;   // second main-counter stage
  localparam int SW_W    = 6;   // swallow counter width
  localparam int A_LO    = 27;  // smallest swallow count
  localparam int A_HI    = 42;  // largest swallow count
  localparam int N_BASE  = PRE_P * MAIN_LO * MAIN_HI;
  localparam int N_MIN   = N_BASE + A_LO;
  localparam int N_MAX   = N_BASE + A_HI;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int P = 64
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic plus_i,
  output logic tick_o
);
  localparam int CW = $clog2(P + 2);
  localparam logic [CW-1:0] LAST_P  = CW'(P - 1);
  localparam logic [CW-1:0] LAST_P1 = CW'(P);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == (plus_i ? LAST_P1 : LAST_P));

  always_ff @(posedge clk_i) begin
    if (rst_i || tick_o) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psd_mod_stage.sv
module psd_mod_stage #(
  parameter int MOD = 12
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic wrap_o
);
  localparam int CW = (MOD > 2) ? $clog2(MOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;

  assign wrap_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i)       cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (en_i)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
  parameter int W  = 6,
  parameter int LO = 27,
  parameter int HI = 42
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] a_i,
  output logic         nz_o
);
  localparam logic [W-1:0] LO_V = W'(LO);
  localparam logic [W-1:0] HI_V = W'(HI);

  logic [W-1:0] cnt_q;
  logic [W-1:0] a_clamped;

  always_comb begin
    if (a_i < LO_V)      a_clamped = LO_V;
    else if (a_i > HI_V) a_clamped = HI_V;
    else                 a_clamped = a_i;
  end

  assign nz_o = (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || load_i)   cnt_q <= a_clamped;
    else if (dec_i && nz_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int P     = PRE_P,
  parameter int M_LO  = MAIN_LO,
  parameter int M_HI  = MAIN_HI,
  parameter int AW    = SW_W,
  parameter int A_MIN = A_LO,
  parameter int A_MAX = A_HI
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [AW-1:0] a_i,
  output logic          div_o,
  output logic          modsel_o
);
  logic pre_tick;
  logic lo_wrap;
  logic period_end;
  logic sw_nz;

  psd_prescaler #(.P(P)) u_pre (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .plus_i (sw_nz),
    .tick_o (pre_tick)
  );

  psd_mod_stage #(.MOD(M_LO)) u_main_lo (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (pre_tick),
    .wrap_o (lo_wrap)
  );

  psd_mod_stage #(.MOD(M_HI)) u_main_hi (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .en_i   (lo_wrap),
    .wrap_o (period_end)
  );

  psd_swallow #(.W(AW), .LO(A_MIN), .HI(A_MAX)) u_sw (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (period_end),
    .dec_i  (pre_tick),
    .a_i    (a_i),
    .nz_o   (sw_nz)
  );

  assign modsel_o = sw_nz;

  always_ff @(posedge clk_i) begin
    if (rst_i) div_o <= 1'b0;
    else       div_o <= period_end;
  end
endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk
  import psd_pkg::*;
(
  input logic clk_i,
  input logic rst_i,
  input logic div_o,
  input logic modsel_o
);
  logic [15:0] gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                gap_q <= '0;
    else if (div_o)           gap_q <= 16'd1;
    else if (gap_q != 16'hFFFF) gap_q <= gap_q + 16'd1;
  end

  assert_low_after_reset_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> !div_o);

  assert_period_window_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    div_o |-> (gap_q >= 16'(N_MIN) && gap_q <= 16'(N_MAX)));

  assert_no_overrun_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    gap_q <= 16'(N_MAX));

  assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    div_o |=> !div_o);

  assert_mode_rise_at_pulse_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(modsel_o) |-> div_o);

  assert_reload_nonzero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    div_o |-> modsel_o);
endmodule

bind psd_divider psd_divider_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .div_o    (div_o),
  .modsel_o (modsel_o)
);

// File: tb/test_psd_divider.sv
module test_psd_divider;
  logic       clk = 1'b0;
  logic       rst_i;
  logic [5:0] a_i;
  logic       div_o;
  logic       modsel_o;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;
  bit done     = 0;

  always #4 clk = ~clk;  // 125 MHz

  psd_divider i_psd_divider (
    .clk_i    (clk),
    .rst_i    (rst_i),
    .a_i      (a_i),
    .div_o    (div_o),
    .modsel_o (modsel_o)
  );

  always @(posedge clk) cycles <= cycles + 1;

  function automatic int clampa(input int a);
    if (a < 27) return 27;
    if (a > 42) return 42;
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts samples until div_o is seen high; optional a_i change at sample chg_at.
  task automatic wait_pulse(input bool_dummy, input int chg_at, input int chg_val,
                            output int n, output int hi);
    n = 0; hi = 0;
    forever begin
      @(negedge clk);
      n++;
      if (modsel_o) hi++;
      if (n == 1 && bool_dummy) check(!div_o, "R3 pulse width", int'(div_o), 0);
      if (n == chg_at) a_i = 6'(chg_val);
      if (div_o) break;
      if (n > 6000) break;
    end
  endtask

  task automatic period_check(input string req, input int aexp, input int n, input int hi);
    check(n == 4608 + clampa(aexp), req, n, 4608 + clampa(aexp));
    check(hi == 65 * clampa(aexp), "R4 cycles at divide-by-65", hi, 65 * clampa(aexp));
  endtask

  task automatic do_reset(input int aval);
    @(negedge clk);
    rst_i = 1'b1;
    a_i   = 6'(aval);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!div_o, "R1 low in reset", int'(div_o), 0);
    end
    rst_i = 1'b0;
  endtask

  initial begin
    int n, hi, prev;
    rst_i = 1'b1;
    a_i   = 6'd27;

    // R1: reset state and first pulse latency
    do_reset(27);
    wait_pulse(0, 0, 0, n, hi);
    period_check("R1 first pulse latency", 27, n, hi);

    // R2: sweep all 16 settings; change applied just after each pulse
    prev = 27;
    for (int a = 28; a <= 42; a++) begin
      a_i = 6'(a);
      wait_pulse(1, 0, 0, n, hi);
      period_check("R2 period for A", prev, n, hi);
      prev = a;
    end
    wait_pulse(1, 0, 0, n, hi);
    period_check("R2 period for A", 42, n, hi);

    // R5: change in mid-period leaves that period alone
    wait_pulse(1, 100, 30, n, hi);
    period_check("R5 period keeps old A", 42, n, hi);
    wait_pulse(1, 0, 0, n, hi);
    period_check("R5 new A in next period", 30, n, hi);

    // R6: clamp low and high
    a_i = 6'd0;
    wait_pulse(1, 0, 0, n, hi);
    period_check("R5 period keeps old A", 30, n, hi);
    wait_pulse(1, 0, 0, n, hi);
    period_check("R6 clamp below range", 0, n, hi);
    a_i = 6'd63;
    wait_pulse(1, 0, 0, n, hi);
    period_check("R6 clamp below range", 0, n, hi);
    wait_pulse(1, 0, 0, n, hi);
    period_check("R6 clamp above range", 63, n, hi);

    // R7: reset in mid-period
    for (int k = 0; k < 500; k++) @(negedge clk);
    do_reset(35);
    wait_pulse(0, 0, 0, n, hi);
    period_check("R7 restart after mid-period reset", 35, n, hi);
    wait_pulse(1, 0, 0, n, hi);
    period_check("R7 steady period after restart", 35, n, hi);

    done = 1;
  end

  initial begin
    wait (done || cycles >= 190000);
    if (!done) check(0, "watchdog expired", cycles, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule